// File: doc/BRIEF.md
# PCI Configuration Cycle Address Generator

This block sits between a host-side configuration request and the system bus that reaches the PCI host bridge. A request names a bus number, a device/function byte, a register offset, an access size (byte, word or dword), a direction and write data. The block decides whether the target sits on the local bus (a Type 0 cycle) or behind a bridge (a Type 1 cycle). It builds the PCI-format configuration address and the sparse host address with the size code folded in. It moves write data into the byte lanes selected by the offset and issues a single access on a simple master port.

Each access runs as a short fixed sequence. The error status is cleared first. The cycle-type field of the configuration control is set for Type 1 accesses. The master request is held until the bus accepts it. The control field is then restored and a one-cycle completion pulse is raised. Read data is shifted back down to bit 0 and trimmed to the access size. A master-abort replaces the result with all ones and raises the error flag. Only one access is in flight at a time, and requests are refused while the block is busy.

Top module: `cfgcyc_top`

## Requirements
- R1: The cycle is Type 1 when the bus number is non-zero and Type 0 when it is zero; `pci_addr[1:0]` is 2'b01 for Type 1 and 2'b00 for Type 0.
- R2: `pci_addr` carries the bus in bits 23:16, the device/function byte in bits 15:8, offset bits 7:2 in bits 7:2, and the type code in bits 1:0.
- R3: `mst_addr` equals ({bus, devfn, offset} shifted left by 5) plus a size code plus `CFG_BASE`. The size code is 0x00 for size 2'b00 (byte), 0x08 for 2'b01 (word), and 0x18 for 2'b10 (dword) and for 2'b11, which is handled as a dword.
- R4: For byte and word accesses, `mst_wdata` is the write data shifted left by 8 times offset[1:0]. For dword accesses it is passed unshifted.
- R5: Unless the access aborts, `rdata` is `mst_rdata` shifted right by 8 times offset[1:0], then masked to 8 bits (byte), 16 bits (word) or 32 bits (dword). Writes form `rdata` the same way.
- R6: When `mst_abort` is high with `mst_ready`, `rdata` is 0xFFFFFFFF and `err` is 1 at `done`. Otherwise `err` is 0.
- R7: `ctl_type` is 2'b01 in every cycle that a Type 1 request is on the master port. It is 2'b00 during Type 0 requests and whenever the block is idle.
- R8: `err_clr` is high for exactly the one cycle right before `mst_valid` first rises for an access.
- R9: A request is accepted only when `req_valid` is high while `busy` is low. A request presented while `busy` is high is ignored and produces no access.
- R10: `done` is a single-cycle pulse in the cycle after the clock edge at which `mst_ready` was seen high. `err` and `rdata` are valid with it.
- R11: While `mst_valid` is high and `mst_ready` is low, `mst_valid`, `mst_addr`, `mst_write` and `mst_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Device (7:3) and function (2:0) |
| req_off | input | 8 | Register byte offset |
| req_size | input | 2 | 00 byte, 01 word, 10/11 dword |
| req_write | input | 1 | 1 for write |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Access in progress |
| err_clr | output | 1 | Clear pulse to the error status register |
| ctl_type | output | 2 | Cycle-type field of the configuration control |
| mst_valid | output | 1 | Master request |
| mst_write | output | 1 | Master direction |
| mst_addr | output | 40 | Sparse host address |
| mst_wdata | output | 32 | Lane-shifted write data |
| pci_addr | output | 24 | PCI-format configuration address |
| mst_ready | input | 1 | Master access completes |
| mst_rdata | input | 32 | Raw read data |
| mst_abort | input | 1 | Target master-aborted or errored |
| done | output | 1 | Completion pulse |
| err | output | 1 | Abort seen on this access |
| rdata | output | 32 | Aligned result |

## Verification
The bench aims at the bus-zero boundary against bus 0x01 and 0xFF. A design that keyed the cycle type on the wrong field would emit 2'b00 for bridged targets and leave `ctl_type` low during them. It sweeps every lane offset for byte and word traffic, where a missing or reversed shift puts data in the wrong lanes or leaves stale upper bytes in reads. It also drives the reserved size code 2'b11, and aborts on reads, writes and Type 0 accesses, which catch a design that returns raw data on abort or forgets the error flag. Finally, it pokes a request while an access is stalled; a design that does not gate acceptance would start a second, unexpected access.

// File: rtl/cfgcyc_pkg.sv
package cfgcyc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLR   = 2'd1,
    ST_ISSUE = 2'd2,
    ST_FIN   = 2'd3
  } seq_state_t;

  localparam logic [1:0] SZ_BYTE  = 2'b00;
  localparam logic [1:0] SZ_WORD  = 2'b01;

  localparam logic [1:0] CT_TYPE0 = 2'b00;
  localparam logic [1:0] CT_TYPE1 = 2'b01;

  // sparse size code folded into the host address
  function automatic logic [4:0] size_code(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_code = 5'h00;
      SZ_WORD: size_code = 5'h08;
      default: size_code = 5'h18;
    endcase
  endfunction

  // number of valid bytes of an access of the given size
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_WORD: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/cfgcyc_addr.sv
module cfgcyc_addr
  import cfgcyc_pkg::*;
#(
  parameter int unsigned BUS_W     = 8,
  parameter int unsigned DF_W      = 8,
  parameter int unsigned OFF_W     = 8,
  parameter int unsigned ADDR_W    = 40,
  parameter int unsigned SPARSE_SH = 5,
  parameter logic [ADDR_W-1:0] CFG_BASE = '0,
  localparam int unsigned BASE_W   = BUS_W + DF_W + OFF_W
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [DF_W-1:0]   devfn,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        size,
  output logic              is_type1,
  output logic [BASE_W-1:0] pci_addr,
  output logic [ADDR_W-1:0] host_addr
);

  logic [BASE_W-1:0] base;
  logic [ADDR_W-1:0] sparse;

  assign is_type1 = |bus;
  assign base     = {bus, devfn, off};
  assign sparse   = ADDR_W'(base) << SPARSE_SH;

  always_comb begin
    host_addr = sparse + ADDR_W'(size_code(size)) + CFG_BASE;
  end

  assign pci_addr = {bus, devfn, off[OFF_W-1:2], (is_type1 ? CT_TYPE1 : CT_TYPE0)};

endmodule

// File: rtl/cfgcyc_lane.sv
module cfgcyc_lane
  import cfgcyc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NBYTE  = DATA_W / 8,
  localparam int unsigned LANE_W = $clog2(NBYTE)
) (
  input  logic [1:0]        size,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [DATA_W-1:0] rdata_raw,
  input  logic              abort,
  output logic [DATA_W-1:0] wdata_out,
  output logic [DATA_W-1:0] rdata_out
);

  logic [LANE_W+2:0] shamt;
  logic [2:0]        nbytes;
  logic [DATA_W-1:0] rd_mask;
  logic [DATA_W-1:0] rd_shift;
  logic              full;

  assign shamt  = {lane, 3'b000};
  assign nbytes = size_bytes(size);
  assign full   = (32'(nbytes) >= NBYTE);

  for (genvar b = 0; b < NBYTE; b++) begin : g_mask
    assign rd_mask[8*b +: 8] = (b < 32'(nbytes)) ? 8'hFF : 8'h00;
  end

  assign wdata_out = full ? wdata_in : (wdata_in << shamt);
  assign rd_shift  = full ? rdata_raw : (rdata_raw >> shamt);
  assign rdata_out = abort ? {DATA_W{1'b1}} : (rd_shift & rd_mask);

endmodule

// File: rtl/cfgcyc_seq.sv
module cfgcyc_seq
  import cfgcyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       is_type1,
  input  logic       mst_ready,
  output logic       accept,
  output logic       busy,
  output logic       err_clr,
  output logic       mst_valid,
  output logic       capture,
  output logic       done,
  output logic [1:0] ctl_type
);

  seq_state_t state_q, state_d;
  logic [1:0] ctl_q, ctl_d;

  assign busy      = (state_q != ST_IDLE);
  assign accept    = req_valid && !busy;
  assign err_clr   = (state_q == ST_CLR);
  assign mst_valid = (state_q == ST_ISSUE);
  assign capture   = mst_valid && mst_ready;
  assign done      = (state_q == ST_FIN);
  assign ctl_type  = ctl_q;

  always_comb begin
    state_d = state_q;
    ctl_d   = ctl_q;
    case (state_q)
      ST_IDLE:  if (accept) state_d = ST_CLR;
      ST_CLR: begin
        state_d = ST_ISSUE;
        ctl_d   = is_type1 ? CT_TYPE1 : CT_TYPE0;
      end
      ST_ISSUE: if (mst_ready) state_d = ST_FIN;
      ST_FIN: begin
        state_d = ST_IDLE;
        ctl_d   = CT_TYPE0;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctl_q   <= CT_TYPE0;
    end else begin
      state_q <= state_d;
      ctl_q   <= ctl_d;
    end
  end

endmodule

// File: rtl/cfgcyc_top.sv
module cfgcyc_top
  import cfgcyc_pkg::*;
#(
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned DF_W    = 8,
  parameter int unsigned OFF_W   = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 40,
  parameter logic [ADDR_W-1:0] CFG_BASE = 40'h87_0000_0000,
  localparam int unsigned PCI_W  = BUS_W + DF_W + OFF_W,
  localparam int unsigned LANE_W = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DF_W-1:0]   req_devfn,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              err_clr,
  output logic [1:0]        ctl_type,
  output logic              mst_valid,
  output logic              mst_write,
  output logic [ADDR_W-1:0] mst_addr,
  output logic [DATA_W-1:0] mst_wdata,
  output logic [PCI_W-1:0]  pci_addr,
  input  logic              mst_ready,
  input  logic [DATA_W-1:0] mst_rdata,
  input  logic              mst_abort,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // captured request
  logic [BUS_W-1:0]  bus_q;
  logic [DF_W-1:0]   devfn_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept;
  logic              capture;
  logic              is_type1;
  logic [DATA_W-1:0] lane_rdata;
  logic              err_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bus_q   <= '0;
      devfn_q <= '0;
      off_q   <= '0;
      size_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      bus_q   <= req_bus;
      devfn_q <= req_devfn;
      off_q   <= req_off;
      size_q  <= req_size;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  cfgcyc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .is_type1  (is_type1),
    .mst_ready (mst_ready),
    .accept    (accept),
    .busy      (busy),
    .err_clr   (err_clr),
    .mst_valid (mst_valid),
    .capture   (capture),
    .done      (done),
    .ctl_type  (ctl_type)
  );

  cfgcyc_addr #(
    .BUS_W    (BUS_W),
    .DF_W     (DF_W),
    .OFF_W    (OFF_W),
    .ADDR_W   (ADDR_W),
    .SPARSE_SH(5),
    .CFG_BASE (CFG_BASE)
  ) u_addr (
    .bus      (bus_q),
    .devfn    (devfn_q),
    .off      (off_q),
    .size     (size_q),
    .is_type1 (is_type1),
    .pci_addr (pci_addr),
    .host_addr(mst_addr)
  );

  cfgcyc_lane #(
    .DATA_W(DATA_W)
  ) u_lane (
    .size     (size_q),
    .lane     (off_q[LANE_W-1:0]),
    .wdata_in (wdata_q),
    .rdata_raw(mst_rdata),
    .abort    (mst_abort),
    .wdata_out(mst_wdata),
    .rdata_out(lane_rdata)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else if (capture) begin
      err_q   <= mst_abort;
      rdata_q <= lane_rdata;
    end
  end

  assign mst_write = wr_q;
  assign err       = err_q;
  assign rdata     = rdata_q;

endmodule

// File: rtl/cfgcyc_chk.sv
module cfgcyc_chk #(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned PCI_W  = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              err_clr,
  input logic [1:0]        ctl_type,
  input logic              mst_valid,
  input logic              mst_write,
  input logic [ADDR_W-1:0] mst_addr,
  input logic [DATA_W-1:0] mst_wdata,
  input logic [PCI_W-1:0]  pci_addr,
  input logic              mst_ready,
  input logic              done,
  input logic              err,
  input logic [DATA_W-1:0] rdata
);

  // R1: type code follows the bus field of the issued address
  p_type_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mst_valid |-> (pci_addr[1:0] == ((|pci_addr[PCI_W-1 -: BUS_W]) ? 2'b01 : 2'b00)));

  // R7: control field tracks the cycle type while the request is out
  p_ctl_type1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_valid && pci_addr[1:0] == 2'b01) |-> (ctl_type == 2'b01));

  p_ctl_type0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_valid && pci_addr[1:0] == 2'b00) |-> (ctl_type == 2'b00));

  p_ctl_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ctl_type == 2'b00));

  // R8: the status clear comes just before the request
  p_clr_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mst_valid) |-> $past(err_clr));

  p_clr_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !err_clr && mst_valid);

  // R9: request while idle starts an access; request only out while busy
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  p_valid_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mst_valid |-> busy);

  // R10: one-cycle completion right after the accepting edge
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_valid && mst_ready) |=> done);

  // R6: abort yields all ones
  p_abort_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (rdata == {DATA_W{1'b1}}));

  // R11: request held stable while stalled
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_valid && !mst_ready) |=> mst_valid && $stable(mst_addr)
      && $stable(mst_wdata) && $stable(mst_write));

endmodule

bind cfgcyc_top cfgcyc_chk #(
  .BUS_W (BUS_W),
  .PCI_W (PCI_W),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .req_valid(req_valid),
  .busy     (busy),
  .err_clr  (err_clr),
  .ctl_type (ctl_type),
  .mst_valid(mst_valid),
  .mst_write(mst_write),
  .mst_addr (mst_addr),
  .mst_wdata(mst_wdata),
  .pci_addr (pci_addr),
  .mst_ready(mst_ready),
  .done     (done),
  .err      (err),
  .rdata    (rdata)
);

// File: tb/tb_cfgcyc_top.sv
module tb_cfgcyc_top;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [39:0] BASE = 40'h87_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_bus = '0, req_devfn = '0, req_off = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        busy, err_clr, mst_valid, mst_write, done, err;
  logic [1:0]  ctl_type;
  logic [39:0] mst_addr;
  logic [31:0] mst_wdata, rdata;
  logic [23:0] pci_addr;
  logic        mst_ready = 1'b0;
  logic [31:0] mst_rdata = '0;
  logic        mst_abort = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgcyc_top #(.CFG_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bus(req_bus),
    .req_devfn(req_devfn), .req_off(req_off), .req_size(req_size),
    .req_write(req_write), .req_wdata(req_wdata), .busy(busy),
    .err_clr(err_clr), .ctl_type(ctl_type), .mst_valid(mst_valid),
    .mst_write(mst_write), .mst_addr(mst_addr), .mst_wdata(mst_wdata),
    .pci_addr(pci_addr), .mst_ready(mst_ready), .mst_rdata(mst_rdata),
    .mst_abort(mst_abort), .done(done), .err(err), .rdata(rdata)
  );

  typedef struct {
    logic [39:0] addr;
    logic [23:0] pci;
    logic [1:0]  ctl;
    logic        wr;
    logic [31:0] wdata;
    logic [31:0] resp;
    logic        abort;
    int          delay;
    logic [31:0] exp_rd;
    logic        exp_err;
  } item_t;

  item_t q_acc[$];
  item_t q_done[$];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int ready_cyc = -10;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // expected values straight from the requirements
  function automatic logic [39:0] e_addr(logic [7:0] b, logic [7:0] df, logic [7:0] o, logic [1:0] s);
    logic [39:0] code;
    code = (s == 2'b00) ? 40'h00 : (s == 2'b01) ? 40'h08 : 40'h18;
    return ({16'h0, b, df, o} << 5) + code + BASE;
  endfunction

  function automatic logic [31:0] e_rd(logic [31:0] raw, logic [7:0] o, logic [1:0] s, logic ab);
    logic [31:0] v;
    if (ab) return 32'hFFFF_FFFF;
    if (s == 2'b00) begin v = raw >> (8*o[1:0]); return v & 32'hFF; end
    if (s == 2'b01) begin v = raw >> (8*o[1:0]); return v & 32'hFFFF; end
    return raw;
  endfunction

  task automatic do_req(input logic [7:0] b, input logic [7:0] df, input logic [7:0] o,
                        input logic [1:0] s, input logic w, input logic [31:0] wd,
                        input logic [31:0] resp, input logic ab, input int dly);
    item_t it;
    it.addr    = e_addr(b, df, o, s);
    it.pci     = {b, df, o[7:2], (b != 0) ? 2'b01 : 2'b00};
    it.ctl     = (b != 0) ? 2'b01 : 2'b00;
    it.wr      = w;
    it.wdata   = (s[1]) ? wd : (wd << (8*o[1:0]));
    it.resp    = resp;
    it.abort   = ab;
    it.delay   = dly;
    it.exp_rd  = e_rd(resp, o, s, ab);
    it.exp_err = ab;
    q_acc.push_back(it);
    q_done.push_back(it);
    while (busy) @(negedge clk);
    req_bus = b; req_devfn = df; req_off = o; req_size = s;
    req_write = w; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // responder: compares the issued access and answers it
  initial begin : responder
    logic prev_clr;
    prev_clr = 1'b0;
    forever begin
      @(negedge clk);
      if (mst_valid && rst_n) begin
        item_t it;
        if (q_acc.size() == 0) begin
          chk("R9 unexpected access", 64'(mst_addr), 64'h0);
          it.delay = 0; it.resp = '0; it.abort = 1'b0;
        end else begin
          it = q_acc.pop_front();
          chk("R8 err_clr before request", 64'(prev_clr), 64'h1);
          chk("R3 mst_addr", 64'(mst_addr), 64'(it.addr));
          chk("R1/R2 pci_addr", 64'(pci_addr), 64'(it.pci));
          chk("R7 ctl_type", 64'(ctl_type), 64'(it.ctl));
          chk("R9 mst_write", 64'(mst_write), 64'(it.wr));
          if (it.wr) chk("R4 mst_wdata", 64'(mst_wdata), 64'(it.wdata));
        end
        for (int k = 0; k < it.delay; k++) begin
          @(negedge clk);
          chk("R11 held request", 64'({mst_valid, mst_addr}), 64'({1'b1, it.addr}));
        end
        mst_ready = 1'b1; mst_rdata = it.resp; mst_abort = it.abort;
        ready_cyc = cyc;
        @(negedge clk);
        mst_ready = 1'b0; mst_abort = 1'b0; mst_rdata = '0;
        prev_clr = 1'b0;
      end else begin
        prev_clr = err_clr;
      end
    end
  end

  // monitor: completion results
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (done && rst_n) begin
        item_t it;
        if (q_done.size() == 0) begin
          chk("R10 unexpected done", 64'h1, 64'h0);
        end else begin
          it = q_done.pop_front();
          chk("R10 done latency", 64'(cyc), 64'(ready_cyc + 1));
          chk("R5/R6 rdata", 64'(rdata), 64'(it.exp_rd));
          chk("R6 err", 64'(err), 64'(it.exp_err));
          @(negedge clk);
          chk("R10 done one cycle", 64'(done), 64'h0);
          chk("R7 ctl_type restored", 64'({busy, ctl_type}), 64'h0);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("reset state", 64'({busy, mst_valid, done, ctl_type, err_clr}), 64'h0);

    // Type 0 dword read
    do_req(8'h00, 8'h19, 8'h10, 2'b10, 1'b0, 32'h0, 32'h1234_5678, 1'b0, 0);
    // Type 1 word read on upper lane
    do_req(8'h05, 8'h42, 8'h0E, 2'b01, 1'b0, 32'h0, 32'hCAFE_1234, 1'b0, 2);
    // byte reads on each lane
    for (int l = 0; l < 4; l++)
      do_req(8'h00, 8'h08, 8'h20 + 8'(l), 2'b00, 1'b0, 32'h0, 32'hA1B2_C3D4, 1'b0, l);
    // byte write lane 1, bus 0x80
    do_req(8'h80, 8'hFF, 8'h05, 2'b00, 1'b1, 32'h0000_005A, 32'h0, 1'b0, 1);
    // word write lane 2, bus 1
    do_req(8'h01, 8'h00, 8'h02, 2'b01, 1'b1, 32'h0000_1234, 32'h0, 1'b0, 0);
    // dword write, bus 0xFF
    do_req(8'hFF, 8'h3A, 8'hFC, 2'b10, 1'b1, 32'hDEAD_BEEF, 32'h0, 1'b0, 0);
    // reserved size code handled as dword (R3)
    do_req(8'h02, 8'h11, 8'h44, 2'b11, 1'b0, 32'h0, 32'h0BAD_F00D, 1'b0, 0);
    // aborts: Type 1 read, Type 0 byte read, write
    do_req(8'h07, 8'h20, 8'h00, 2'b10, 1'b0, 32'h0, 32'h1111_2222, 1'b1, 1);
    do_req(8'h00, 8'h30, 8'h03, 2'b00, 1'b0, 32'h0, 32'h3333_4444, 1'b1, 0);
    do_req(8'h09, 8'h30, 8'h04, 2'b10, 1'b1, 32'h5555_6666, 32'h0, 1'b1, 0);

    // R9: request while busy is ignored
    do_req(8'h03, 8'h10, 8'h08, 2'b10, 1'b0, 32'h0, 32'h7777_8888, 1'b0, 6);
    @(negedge clk);
    chk("R9 busy during access", 64'(busy), 64'h1);
    req_bus = 8'h44; req_devfn = 8'h44; req_off = 8'h44; req_size = 2'b10;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;

    repeat (30) @(negedge clk);
    chk("R9 no extra access", 64'(q_acc.size() + q_done.size()), 64'h0);
    chk("R9 idle after all", 64'({busy, mst_valid}), 64'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule